// File: doc/BRIEF.md
# Masked SIMD Processing-Element Array

This block is a grid of identical processing elements (PEs) driven by one instruction stream. A small sequencer reads a program from its own control memory, one instruction per clock. It handles scalar instructions itself. Vector instructions go to every PE at once. Each PE holds three working registers (A, B, C), a routing register R, an address register D, an index register I, a status bit and a private local memory. A PE whose status bit is clear ignores every vector instruction.

A scalar enable instruction loads the status bit of every PE in one cycle. The pattern it sets stays in force until the next enable instruction. The PEs form a square two-dimensional grid whose edges wrap around to the opposite side, so the grid is a torus. A route instruction moves data between neighbours: in one cycle every active PE takes its chosen neighbour's R value. Local memory is addressed by D plus I inside each PE, so different PEs can reach different words in the same step. A program is written through a port, started with a pulse, and ends with a halt instruction that raises `done`. A read port shows the A register of any chosen PE.

Top module: `simd_array`

## Requirements
- R1: After reset, `done` is 0. Every PE register, every status bit and all local memory are zero, so `rd_a` reads 0 for every PE.
- R2: The scalar enable instruction (opcode 0x02) sets the status bit of PE p to immediate bit p. It applies to the vector instructions that follow and stays in force, across programs too, until the next enable instruction.
- R3: A PE whose status bit is 0 leaves its registers and its local memory unchanged when any vector instruction is broadcast, stores and routes included.
- R4: An opcode with bit 7 clear is scalar and never reaches the PEs: NOP (0x00), HALT (0x01) and enable (0x02) leave all PE registers unchanged.
- R5: The vector ALU and move operations are ADD 0x82 (A=B+C), SUB 0x83 (A=B-C), AND 0x84, OR 0x85 and XOR 0x86 (A=B op C), all modulo 2^DW. They also include LIM 0x8A (A=immediate), LID 0x8B (A=own PE index), MAB 0x8C (B=A) and MAC 0x8D (C=A).
- R6: SETD 0x8E loads D from the low address bits of the immediate, and SETI 0x8F loads I from the low address bits of A. LDA 0x80 loads A from local word (D+I) mod DEPTH, and STA 0x81 stores A there. Each PE uses its own D and I.
- R7: A2R 0x87 copies A into R, and R2A 0x88 copies R into A. ROUTE 0x89, with immediate bits [1:0] set to 0 north, 1 south, 2 east or 3 west, loads R from the R that the neighbour in that direction held before the edge. PE index is row*COLS+col, with row 0 at the north edge and col 0 at the west edge. The edges wrap around.
- R8: Instruction word = {opcode[7:0], immediate[IMMW-1:0]}. A `start` pulse sampled while idle resets the program counter to 0. The instruction at address k executes on the (k+2)th rising edge counting the start edge. A HALT at address h raises `done` on edge h+2, and `done` stays high until the next start.
- R9: `rd_a` shows, without a clock, the A register of the PE selected by `rd_pe`.
- R10: A write with `prog_we` high stores `prog_data` at `prog_addr` in the control memory, and a later run executes the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Control-memory write enable |
| prog_addr | input | PAW | Control-memory write address |
| prog_data | input | IW | Instruction word to write |
| start | input | 1 | Start pulse; begins a run at address 0 |
| done | output | 1 | High once HALT has executed |
| rd_pe | input | PEW | PE selected for the read port |
| rd_a | output | DW | A register of the selected PE |

## Verification
The bench builds a 4x4 grid with 16-bit words, 8-word local memories and a 32-entry control memory. A four-wide torus lets every direction wrap at both edges. A double route can then cross the seam. An 8-word memory wraps D+I, so PE-specific addresses fold onto shared words and can be checked. With 16-bit words, SUB and XOR wrap-around show up with small operands. Sixteen PEs keep it cheap to check every PE after every program.

// File: rtl/simd_pkg.sv
`timescale 1ns/1ps
package simd_pkg;
   localparam logic [7:0] OP_NOP   = 8'h00;
   localparam logic [7:0] OP_HALT  = 8'h01;
   localparam logic [7:0] OP_SETEN = 8'h02;
   localparam logic [7:0] OP_LDA   = 8'h80;
   localparam logic [7:0] OP_STA   = 8'h81;
   localparam logic [7:0] OP_ADD   = 8'h82;
   localparam logic [7:0] OP_SUB   = 8'h83;
   localparam logic [7:0] OP_AND   = 8'h84;
   localparam logic [7:0] OP_OR    = 8'h85;
   localparam logic [7:0] OP_XOR   = 8'h86;
   localparam logic [7:0] OP_A2R   = 8'h87;
   localparam logic [7:0] OP_R2A   = 8'h88;
   localparam logic [7:0] OP_ROUTE = 8'h89;
   localparam logic [7:0] OP_LIM   = 8'h8A;
   localparam logic [7:0] OP_LID   = 8'h8B;
   localparam logic [7:0] OP_MAB   = 8'h8C;
   localparam logic [7:0] OP_MAC   = 8'h8D;
   localparam logic [7:0] OP_SETD  = 8'h8E;
   localparam logic [7:0] OP_SETI  = 8'h8F;
   localparam int NDIR = 4;
endpackage

// File: rtl/simd_seq.sv
`timescale 1ns/1ps
module simd_seq
   import simd_pkg::*;
#(
   parameter int IMMW   = 64,
   parameter int PDEPTH = 64,
   localparam int IW    = IMMW + 8,
   localparam int PAW   = $clog2(PDEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prog_we,
   input  logic [PAW-1:0]  prog_addr,
   input  logic [IW-1:0]   prog_data,
   input  logic            start,
   output logic            done,
   output logic            vec_valid,
   output logic            en_ld,
   output logic [7:0]      op,
   output logic [IMMW-1:0] imm
);
   logic [IW-1:0]  pmem [PDEPTH];
   logic [PAW-1:0] pc_q;
   logic           run_q;
   logic           done_q;
   logic [IW-1:0]  instr;

   always_ff @(posedge clk) begin
      if (prog_we) pmem[prog_addr] <= prog_data;
   end

   always_comb begin
      instr     = pmem[pc_q];
      op        = instr[IW-1 -: 8];
      imm       = instr[IMMW-1:0];
      vec_valid = run_q && op[7];
      en_ld     = run_q && (op == OP_SETEN);
      done      = done_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q   <= '0;
         run_q  <= 1'b0;
         done_q <= 1'b0;
      end else if (!run_q) begin
         if (start) begin
            pc_q   <= '0;
            run_q  <= 1'b1;
            done_q <= 1'b0;
         end
      end else if (op == OP_HALT) begin
         run_q  <= 1'b0;
         done_q <= 1'b1;
      end else begin
         pc_q <= pc_q + 1'b1;
      end
   end

   AST_HALT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && op == OP_HALT) |=> (done && !run_q)); // R8
   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start) |=> done_q); // R8
   AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && op != OP_HALT) |=> (pc_q == $past(pc_q) + 1'b1)); // R8
   AST_START_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && start) |=> (run_q && pc_q == '0 && !done_q)); // R8
endmodule

// File: rtl/simd_pe.sv
`timescale 1ns/1ps
module simd_pe
   import simd_pkg::*;
#(
   parameter int DW    = 64,
   parameter int DEPTH = 16,
   parameter int ID    = 0,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vec_valid,
   input  logic [7:0]          op,
   input  logic [DW-1:0]       opnd,
   input  logic                en_ld,
   input  logic                en_bit,
   input  logic [NDIR-1:0][DW-1:0] nbr_r,
   output logic [DW-1:0]       r_q,
   output logic [DW-1:0]       a_q
);
   localparam logic [DW-1:0] ID_W = DW'(ID);

   logic [DW-1:0]            b_q, c_q;
   logic [AW-1:0]            d_q, i_q;
   logic                     stat_q;
   logic [DEPTH-1:0][DW-1:0] mem_q;
   logic [AW-1:0]            addr;
   logic                     act;

   always_comb begin
      act  = vec_valid && stat_q;
      addr = d_q + i_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q    <= '0;
         b_q    <= '0;
         c_q    <= '0;
         r_q    <= '0;
         d_q    <= '0;
         i_q    <= '0;
         stat_q <= 1'b0;
         mem_q  <= '0;
      end else begin
         if (en_ld) stat_q <= en_bit;
         if (act) begin
            case (op)
               OP_LDA:   a_q <= mem_q[addr];
               OP_STA:   mem_q[addr] <= a_q;
               OP_ADD:   a_q <= b_q + c_q;
               OP_SUB:   a_q <= b_q - c_q;
               OP_AND:   a_q <= b_q & c_q;
               OP_OR:    a_q <= b_q | c_q;
               OP_XOR:   a_q <= b_q ^ c_q;
               OP_A2R:   r_q <= a_q;
               OP_R2A:   a_q <= r_q;
               OP_ROUTE: r_q <= nbr_r[opnd[1:0]];
               OP_LIM:   a_q <= opnd;
               OP_LID:   a_q <= ID_W;
               OP_MAB:   b_q <= a_q;
               OP_MAC:   c_q <= a_q;
               OP_SETD:  d_q <= opnd[AW-1:0];
               OP_SETI:  i_q <= a_q[AW-1:0];
               default:  ;
            endcase
         end
      end
   end

   AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_q |=> ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(r_q)
                   && $stable(d_q) && $stable(i_q) && $stable(mem_q))); // R3
   AST_STATUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      en_ld |=> (stat_q == $past(en_bit))); // R2
   AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !en_ld |=> $stable(stat_q)); // R2
   AST_SCALAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |=> ($stable(a_q) && $stable(r_q) && $stable(mem_q))); // R4
   AST_ROUTE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (act && op == OP_ROUTE) |=> (r_q == $past(nbr_r[opnd[1:0]]))); // R7
endmodule

// File: rtl/simd_array.sv
`timescale 1ns/1ps
module simd_array
   import simd_pkg::*;
#(
   parameter int ROWS   = 8,
   parameter int COLS   = 8,
   parameter int DW     = 64,
   parameter int DEPTH  = 16,
   parameter int PDEPTH = 64,
   localparam int NPE   = ROWS * COLS,
   localparam int PEW   = $clog2(NPE),
   localparam int PAW   = $clog2(PDEPTH),
   localparam int IMMW  = (NPE > DW) ? NPE : DW,
   localparam int IW    = IMMW + 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           prog_we,
   input  logic [PAW-1:0] prog_addr,
   input  logic [IW-1:0]  prog_data,
   input  logic           start,
   output logic           done,
   input  logic [PEW-1:0] rd_pe,
   output logic [DW-1:0]  rd_a
);
   if (ROWS < 2 || COLS < 2) begin : g_bad_grid
      $error("simd_array: grid needs at least 2 rows and 2 columns");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("simd_array: DEPTH must be a power of two >= 2");
   end
   if (PDEPTH < 2 || (PDEPTH & (PDEPTH - 1)) != 0) begin : g_bad_pdepth
      $error("simd_array: PDEPTH must be a power of two >= 2");
   end
   if (DW < PEW || DW < $clog2(DEPTH) || DW < 2) begin : g_bad_dw
      $error("simd_array: DW too narrow for PE index or address");
   end

   logic            vec_valid, en_ld;
   logic [7:0]      op;
   logic [IMMW-1:0] imm;
   logic [NPE-1:0][DW-1:0] r_all;
   logic [NPE-1:0][DW-1:0] a_all;

   simd_seq #(.IMMW(IMMW), .PDEPTH(PDEPTH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_we   (prog_we),
      .prog_addr (prog_addr),
      .prog_data (prog_data),
      .start     (start),
      .done      (done),
      .vec_valid (vec_valid),
      .en_ld     (en_ld),
      .op        (op),
      .imm       (imm)
   );

   for (genvar rr = 0; rr < ROWS; rr++) begin : g_row
      for (genvar cc = 0; cc < COLS; cc++) begin : g_col
         localparam int ME = rr * COLS + cc;
         localparam int NN = ((rr + ROWS - 1) % ROWS) * COLS + cc;
         localparam int SS = ((rr + 1) % ROWS) * COLS + cc;
         localparam int EE = rr * COLS + (cc + 1) % COLS;
         localparam int WW = rr * COLS + (cc + COLS - 1) % COLS;
         simd_pe #(.DW(DW), .DEPTH(DEPTH), .ID(ME)) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .vec_valid (vec_valid),
            .op        (op),
            .opnd      (imm[DW-1:0]),
            .en_ld     (en_ld),
            .en_bit    (imm[ME]),
            .nbr_r     ({r_all[WW], r_all[EE], r_all[SS], r_all[NN]}),
            .r_q       (r_all[ME]),
            .a_q       (a_all[ME])
         );
      end
   end

   if (NPE == (1 << PEW)) begin : g_rd_full
      assign rd_a = a_all[rd_pe];
   end else begin : g_rd_guard
      assign rd_a = (int'(rd_pe) < NPE) ? a_all[rd_pe] : '0;
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!vec_valid && !en_ld)); // R4
endmodule

// File: tb/simd_array_tb.sv
`timescale 1ns/1ps
module simd_array_tb;
   localparam int ROWS = 4, COLS = 4, DW = 16, DEPTH = 8, PDEPTH = 32;
   localparam int NPE = ROWS * COLS;
   localparam int PEW = $clog2(NPE);
   localparam int PAW = $clog2(PDEPTH);
   localparam int IW  = 24;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           prog_we = 1'b0;
   logic [PAW-1:0] prog_addr = '0;
   logic [IW-1:0]  prog_data = '0;
   logic           start = 1'b0;
   logic           done;
   logic [PEW-1:0] rd_pe = '0;
   logic [DW-1:0]  rd_a;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [IW-1:0] prog [PDEPTH];
   int plen = 0;

   always #2 clk = ~clk;

   simd_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .DEPTH(DEPTH), .PDEPTH(PDEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
      .prog_data(prog_data), .start(start), .done(done), .rd_pe(rd_pe), .rd_a(rd_a)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic emit(input logic [7:0] op, input logic [15:0] imm);
      prog[plen] = {op, imm};
      plen++;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R10: program written through the write port, then run; R8 cycle count
   task automatic run_prog(input string tag);
      int cnt;
      for (int k = 0; k < plen; k++) begin
         @(negedge clk); prog_we = 1'b1; prog_addr = PAW'(k); prog_data = prog[k];
      end
      @(negedge clk); prog_we = 1'b0;
      start = 1'b1;
      @(posedge clk); cnt = 1;
      @(negedge clk); start = 1'b0;
      while (!done && cnt < 500) begin
         @(posedge clk); cnt++;
         @(negedge clk);
      end
      chk({tag, " R8 cycles to done"}, cnt, plen + 1);
      plen = 0;
   endtask

   task automatic read_a(input int p, output int v);
      rd_pe = PEW'(p);
      #0.5;
      v = int'(rd_a);
   endtask

   task automatic t_reset();
      int v;
      do_reset();
      chk("R1 done after reset", int'(done), 0);
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R1 R9 A after reset", v, 0);
      end
      // R3: status is 0 after reset, so a vector op is ignored
      emit(8'h8A, 16'h0009); emit(8'h01, 0);
      run_prog("R3 before enable");
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R3 inactive after reset", v, 0);
      end
   endtask

   task automatic t_alu(input logic [7:0] op, input logic [15:0] cv, input string tag);
      int v, e;
      emit(8'h02, 16'hFFFF); emit(8'h8B, 0); emit(8'h8C, 0);
      emit(8'h8A, cv); emit(8'h8D, 0); emit(op, 0); emit(8'h01, 0);
      run_prog(tag);
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         case (op)
            8'h82: e = (p + cv) & 16'hFFFF;
            8'h83: e = (p - cv) & 16'hFFFF;
            8'h84: e = p & cv;
            8'h85: e = p | cv;
            default: e = p ^ cv;
         endcase
         chk({tag, " R5 R10"}, v, e);
      end
   endtask

   task automatic t_mask();
      int v;
      logic [15:0] m = 16'hA5C3;
      do_reset();
      emit(8'h02, 16'hFFFF); emit(8'h8A, 16'h0001); emit(8'h02, m);
      emit(8'h8A, 16'h0007); emit(8'h00, 0); emit(8'h8C, 0);
      emit(8'h8D, 0); emit(8'h82, 0); emit(8'h01, 0);
      run_prog("mask");
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R2 R3 mask persists", v, m[p] ? 14 : 1);
      end
   endtask

   task automatic t_scalar();
      int v;
      do_reset();
      emit(8'h02, 16'hFFFF); emit(8'h8A, 16'h1234); emit(8'h00, 0);
      emit(8'h02, 16'h0000); emit(8'h00, 0); emit(8'h01, 0);
      run_prog("scalar");
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R4 scalar ops leave A", v, 16'h1234);
      end
      repeat (5) @(negedge clk);
      chk("R8 done holds", int'(done), 1);
   endtask

   task automatic t_mem();
      int v;
      do_reset();
      emit(8'h02, 16'hFFFF); emit(8'h8B, 0); emit(8'h8F, 0); emit(8'h8E, 16'h0002);
      emit(8'h8C, 0); emit(8'h8A, 16'd100); emit(8'h8D, 0); emit(8'h82, 0);
      emit(8'h81, 0); emit(8'h8A, 0); emit(8'h80, 0); emit(8'h01, 0);
      run_prog("mem store");
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R6 load back own address", v, p + 100);
      end
      emit(8'h8A, 0); emit(8'h8F, 0); emit(8'h8E, 16'h0002); emit(8'h80, 0); emit(8'h01, 0);
      run_prog("mem shared");
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R6 per-PE address wrap", v, ((2 + p) % DEPTH == 2) ? p + 100 : 0);
      end
   endtask

   task automatic t_mem_mask();
      int v;
      do_reset();
      emit(8'h02, 16'hFFFF); emit(8'h8A, 0); emit(8'h8F, 0); emit(8'h8E, 16'h0005);
      emit(8'h8A, 16'd55); emit(8'h02, 16'h00FF); emit(8'h81, 0);
      emit(8'h02, 16'hFFFF); emit(8'h8A, 0); emit(8'h80, 0); emit(8'h01, 0);
      run_prog("masked store");
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R3 masked store", v, (p < 8) ? 55 : 0);
      end
   endtask

   function automatic int nbr(input int p, input int dir);
      int r = p / COLS, c = p % COLS;
      case (dir)
         0: return ((r + ROWS - 1) % ROWS) * COLS + c;
         1: return ((r + 1) % ROWS) * COLS + c;
         2: return r * COLS + (c + 1) % COLS;
         default: return r * COLS + (c + COLS - 1) % COLS;
      endcase
   endfunction

   task automatic t_route();
      int v;
      logic [15:0] m = 16'h0F0F;
      for (int dir = 0; dir < 4; dir++) begin
         do_reset();
         emit(8'h02, 16'hFFFF); emit(8'h8B, 0); emit(8'h87, 0);
         emit(8'h89, 16'(dir)); emit(8'h88, 0); emit(8'h01, 0);
         run_prog("route");
         for (int p = 0; p < NPE; p++) begin
            read_a(p, v);
            chk($sformatf("R7 route dir %0d", dir), v, nbr(p, dir));
         end
      end
      do_reset();
      emit(8'h02, 16'hFFFF); emit(8'h8B, 0); emit(8'h87, 0);
      emit(8'h89, 16'd2); emit(8'h89, 16'd2); emit(8'h88, 0); emit(8'h01, 0);
      run_prog("route twice");
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R7 double east", v, nbr(nbr(p, 2), 2));
      end
      do_reset();
      emit(8'h02, 16'hFFFF); emit(8'h8B, 0); emit(8'h87, 0); emit(8'h02, m);
      emit(8'h89, 16'd2); emit(8'h02, 16'hFFFF); emit(8'h88, 0); emit(8'h01, 0);
      run_prog("route masked");
      for (int p = 0; p < NPE; p++) begin
         read_a(p, v);
         chk("R3 R7 masked route", v, m[p] ? nbr(p, 2) : p);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      do_reset();
      t_alu(8'h82, 16'h0005, "add");
      t_alu(8'h83, 16'h0005, "sub");
      t_alu(8'h84, 16'h00F3, "and");
      t_alu(8'h85, 16'h0F0C, "or");
      t_alu(8'h86, 16'hFFFF, "xor");
      t_mask();
      t_scalar();
      t_mem();
      t_mem_mask();
      t_route();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule